// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block builds the byte that a flash-style memory returns on a read while an embedded program or erase is in progress, or while a sector erase is held in suspend. Instead of array contents, the read returns a status byte: a polling bit that tells a host whether the operation is still running, two bits that flip from one read access to the next, and a sticky error bit that reports a time-limit failure. The host polls it by reading repeatedly. It needs no further command for this.

The array controller tells the block when an operation starts (its kind, the byte being programmed, the sector selected for erase, and whether the target is protected). It also reports completion, suspend, a time-limit overrun and a reset command. The read path supplies the sector of each read address, the array byte at that address, and a one-cycle strobe at the end of each completed read access. The block then either passes the array byte through or replaces it with status. A protected target gets a short, parameterised toggle window, after which the block returns to array data with nothing changed.

Top module: `estat_gen`

## Requirements
- R1: After reset no operation is active and the output equals `array_data_i` for every read sector.
- R2: During a byte program, status bit 7 is the complement of bit 7 of the byte being programmed. Bits 4, 3, 1 and 0 of every status byte are 0.
- R3: During an active erase (`kind_i` 2'b01 sector, 2'b10 chip), status bit 7 is 0. A read inside the suspended sector returns bit 7 as 1.
- R4: Status bit 6 inverts after each read strobe while an operation is active, whatever the read sector. It holds its value while an erase is suspended.
- R5: Status bit 2 inverts after a read strobe only when the read sector is selected for erase: the given sector for a sector erase, every sector for a chip erase, no sector for a program. This holds both while the erase is active and while it is suspended.
- R6: While a sector erase is suspended (`suspend_i` high), a read outside the erase sector returns array data. `suspend_i` has no effect during a program or a chip erase.
- R7: A `limit_i` pulse during an operation sets status bit 5 to 1. The other status bits keep working, and `done_i` no longer ends the operation. Only `reset_cmd_i` clears the bit and returns the block to array data. `reset_cmd_i` has no effect while the operation is still running normally.
- R8: A start with `prot_i` high shows status for exactly PROG_WIN clock cycles (program) or ERASE_WIN clock cycles (erase). The block then returns to array data by itself.
- R9: Both toggle bits are 0 on the first read after an accepted start, whatever values they held before.
- R10: `done_i` ends an active operation and returns the block to array data. It has no effect while an erase is suspended. `start_i` is ignored while any operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: an embedded operation begins |
| kind_i | input | 2 | 00 program, 01 sector erase, 10 chip erase |
| prot_i | input | 1 | Target is protected; show a toggle window only |
| prog_data_i | input | 8 | Byte being programmed |
| erase_sector_i | input | SECT_W | Sector selected for sector erase |
| done_i | input | 1 | One-cycle pulse: embedded operation completed |
| suspend_i | input | 1 | Level: sector erase is suspended |
| limit_i | input | 1 | One-cycle pulse: internal pulse-count limit exceeded |
| reset_cmd_i | input | 1 | One-cycle pulse: reset command written |
| rd_strobe_i | input | 1 | One-cycle pulse at the end of each read access |
| rd_sector_i | input | SECT_W | Sector of the current read address |
| array_data_i | input | 8 | Array byte at the current read address |
| rd_data_o | output | 8 | Byte to drive on the data bus |

## Verification
On every cycle, the assertions check these properties: each toggle bit flips on a strobe only while it is enabled and otherwise stays put, and both toggles clear after an accepted start. They also check that the error bit stays set until a reset command, that the unused status bits are always zero, that the protection window counter stays in range, and that an idle block passes array data straight through. Some behaviour only the bench scenarios can show. These are the cycle-exact lengths of the two protection windows and the value of bit 7 for each operation kind. They also include the sector-by-sector split between status and array data under suspend, and the fact that done, reset, suspend and start pulses are ignored in the phases where they must be.

// File: rtl/estat_pkg.sv
package estat_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10
  } op_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RUN  = 2'b01,
    PH_PROT = 2'b10,
    PH_FAIL = 2'b11
  } phase_e;

  // Assemble a status byte; bits 4,3,1,0 are always zero.
  function automatic logic [7:0] pack_status(input logic poll, input logic tgl,
                                             input logic err, input logic tgl2);
    return {poll, tgl, err, 2'b00, tgl2, 2'b00};
  endfunction

  // True when a read sector falls inside the set selected for erase.
  function automatic logic sector_hit(input op_kind_e kind, input logic [7:0] sel,
                                      input logic [7:0] rd);
    case (kind)
      OP_CHIP: return 1'b1;
      OP_SECT: return sel == rd;
      default: return 1'b0;
    endcase
  endfunction

  // Polling bit: inverted data bit for program, 0 while erasing, 1 when suspended.
  function automatic logic poll_bit(input op_kind_e kind, input logic data7,
                                    input logic susp);
    if (kind == OP_PROG) return ~data7;
    return susp;
  endfunction

endpackage

// File: rtl/estat_phase.sv
module estat_phase
  import estat_pkg::*;
#(
  parameter int SECT_W    = 3,
  parameter int PROG_WIN  = 100,
  parameter int ERASE_WIN = 5000,
  localparam int MAXW  = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN,
  localparam int CNT_W = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  op_kind_e          kind_i,
  input  logic              prot_i,
  input  logic              data7_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic              done_i,
  input  logic              suspend_i,
  input  logic              limit_i,
  input  logic              reset_cmd_i,
  output phase_e            phase_o,
  output op_kind_e          kind_o,
  output logic              data7_o,
  output logic [SECT_W-1:0] sector_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              accept_o,
  output logic              susp_o
);

  phase_e            phase_q;
  op_kind_e          kind_q;
  logic              data7_q;
  logic [SECT_W-1:0] sector_q;
  logic [CNT_W-1:0]  cnt_q;

  assign accept_o = start_i && (phase_q == PH_IDLE);
  assign susp_o   = (phase_q == PH_RUN) && (kind_q == OP_SECT) && suspend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      kind_q   <= OP_PROG;
      data7_q  <= 1'b0;
      sector_q <= '0;
      cnt_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          kind_q   <= kind_i;
          data7_q  <= data7_i;
          sector_q <= sector_i;
          if (prot_i) begin
            phase_q <= PH_PROT;
            cnt_q   <= (kind_i == OP_PROG) ? CNT_W'(PROG_WIN - 1) : CNT_W'(ERASE_WIN - 1);
          end else begin
            phase_q <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (limit_i)                   phase_q <= PH_FAIL;
          else if (done_i && !susp_o)    phase_q <= PH_IDLE;
        end
        PH_PROT: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: if (reset_cmd_i) phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign kind_o   = kind_q;
  assign data7_o  = data7_q;
  assign sector_o = sector_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/estat_toggle.sv
module estat_toggle #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             rd_i,
  input  logic [LANES-1:0] en_i,
  output logic [LANES-1:0] q_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              bit_q <= 1'b0;
      else if (clear_i)        bit_q <= 1'b0;
      else if (rd_i && en_i[g]) bit_q <= ~bit_q;
    end
    assign q_o[g] = bit_q;
  end

endmodule

// File: rtl/estat_gen.sv
module estat_gen
  import estat_pkg::*;
#(
  parameter int SECT_W    = 3,
  parameter int PROG_WIN  = 100,
  parameter int ERASE_WIN = 5000,
  localparam int MAXW  = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN,
  localparam int CNT_W = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic              prot_i,
  input  logic [7:0]        prog_data_i,
  input  logic [SECT_W-1:0] erase_sector_i,
  input  logic              done_i,
  input  logic              suspend_i,
  input  logic              limit_i,
  input  logic              reset_cmd_i,
  input  logic              rd_strobe_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        rd_data_o
);

  phase_e            phase;
  op_kind_e          kind;
  logic              data7;
  logic [SECT_W-1:0] sel_sector;
  logic [CNT_W-1:0]  cnt;
  logic              accept;
  logic              susp;
  logic              busy;
  logic              hit;
  logic              show_status;
  logic              err;
  logic              flip6_en;
  logic              flip2_en;
  logic              tog6;
  logic              tog2;
  logic [1:0]        tog_q;

  estat_phase #(
    .SECT_W(SECT_W), .PROG_WIN(PROG_WIN), .ERASE_WIN(ERASE_WIN)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(op_kind_e'(kind_i)),
    .prot_i(prot_i), .data7_i(prog_data_i[7]), .sector_i(erase_sector_i),
    .done_i(done_i), .suspend_i(suspend_i), .limit_i(limit_i),
    .reset_cmd_i(reset_cmd_i), .phase_o(phase), .kind_o(kind), .data7_o(data7),
    .sector_o(sel_sector), .cnt_o(cnt), .accept_o(accept), .susp_o(susp)
  );

  assign busy        = (phase != PH_IDLE);
  assign err         = (phase == PH_FAIL);
  assign hit         = sector_hit(kind, 8'(sel_sector), 8'(rd_sector_i));
  assign flip6_en    = busy && !susp;
  assign flip2_en    = busy && hit;
  assign show_status = busy && !(susp && !hit);

  estat_toggle #(.LANES(2)) u_toggle (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .rd_i(rd_strobe_i),
    .en_i({flip2_en, flip6_en}), .q_o(tog_q)
  );

  assign tog6 = tog_q[0];
  assign tog2 = tog_q[1];

  assign rd_data_o = show_status ? pack_status(poll_bit(kind, data7, susp), tog6, err, tog2)
                                 : array_data_i;

endmodule

// File: rtl/estat_gen_chk.sv
module estat_gen_chk
  import estat_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int MAXW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe_i,
  input logic             reset_cmd_i,
  input logic [7:0]       array_data_i,
  input logic [7:0]       rd_data_o,
  input phase_e           phase,
  input logic [CNT_W-1:0] cnt,
  input logic             accept,
  input logic             flip6_en,
  input logic             flip2_en,
  input logic             show_status,
  input logic             err,
  input logic             tog6,
  input logic             tog2
);

  // R4
  tog6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && flip6_en && !accept) |=> (tog6 != $past(tog6)));

  // R4
  tog6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_strobe_i && flip6_en) && !accept) |=> $stable(tog6));

  // R5
  tog2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_strobe_i && flip2_en) && !accept) |=> $stable(tog2));

  // R9
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!tog6 && !tog2));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !reset_cmd_i) |=> err);

  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_status |-> ((rd_data_o & 8'h1B) == 8'h00));

  // R8
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROT) |-> (int'(cnt) < MAXW));

  // R10
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (rd_data_o == array_data_i));

endmodule

bind estat_gen estat_gen_chk #(.CNT_W(CNT_W), .MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe_i(rd_strobe_i), .reset_cmd_i(reset_cmd_i),
  .array_data_i(array_data_i), .rd_data_o(rd_data_o), .phase(phase), .cnt(cnt),
  .accept(accept), .flip6_en(flip6_en), .flip2_en(flip2_en),
  .show_status(show_status), .err(err), .tog6(tog6), .tog2(tog2)
);

// File: tb/test_estat_gen.sv
module test_estat_gen;

  localparam int SW = 3;
  localparam int PW = 5;
  localparam int EW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0, prot_i = 0, done_i = 0, suspend_i = 0;
  logic          limit_i = 0, reset_cmd_i = 0, rd_strobe_i = 0;
  logic [1:0]    kind_i = 0;
  logic [7:0]    prog_data_i = 0, array_data_i = 8'hA5;
  logic [SW-1:0] erase_sector_i = 0, rd_sector_i = 0;
  logic [7:0]    rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic e6, e2;

  always #10 clk = ~clk;

  estat_gen #(.SECT_W(SW), .PROG_WIN(PW), .ERASE_WIN(EW)) i_estat_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .prot_i(prot_i),
    .prog_data_i(prog_data_i), .erase_sector_i(erase_sector_i), .done_i(done_i),
    .suspend_i(suspend_i), .limit_i(limit_i), .reset_cmd_i(reset_cmd_i),
    .rd_strobe_i(rd_strobe_i), .rd_sector_i(rd_sector_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] stat(logic b7, logic b6, logic b5, logic b2);
    return (8'(b7) << 7) | (8'(b6) << 6) | (8'(b5) << 5) | (8'(b2) << 2);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One read access: compare the byte, then strobe so the next read sees the flip.
  task automatic rd(string tag, int sec, logic [7:0] arr, logic [7:0] exp);
    rd_sector_i = SW'(sec);
    array_data_i = arr;
    rd_strobe_i = 1'b1;
    #2;
    check(tag, rd_data_o, exp);
    @(negedge clk);
    rd_strobe_i = 1'b0;
  endtask

  task automatic start(logic [1:0] k, logic [7:0] d, int s, logic p);
    kind_i = k; prog_data_i = d; erase_sector_i = SW'(s); prot_i = p;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; prot_i = 1'b0;
  endtask

  task automatic pulse_done();
    done_i = 1'b1; @(negedge clk); done_i = 1'b0;
  endtask

  task automatic pulse_reset();
    reset_cmd_i = 1'b1; @(negedge clk); reset_cmd_i = 1'b0;
  endtask

  task automatic pulse_limit();
    limit_i = 1'b1; @(negedge clk); limit_i = 1'b0;
  endtask

  initial begin : watchdog
    #3000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1: reset passes array data
    for (int i = 0; i < 4; i++) begin
      rd_sector_i = SW'(i); array_data_i = 8'(i * 37 + 3);
      #2 check("R1 reset pass", rd_data_o, 8'(i * 37 + 3));
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 after reset", 2, 8'h3C, 8'h3C);

    // Program: R2, R4, R5 (DQ2 never flips), R6 (suspend ignored), R10
    for (int b = 0; b < 2; b++) begin
      start(2'b00, {b[0], 7'h35}, 0, 1'b0);
      e6 = 0;
      for (int i = 0; i < 16; i++) begin
        suspend_i = (i >= 8);
        rd("R2 R4 R5 R6 program status", i % 8, 8'hA5, stat(~b[0], e6, 0, 0));
        e6 = ~e6;
      end
      suspend_i = 0;
      // R10: a start while busy is ignored
      start(2'b01, 8'h00, 3, 1'b0);
      rd("R10 start ignored", 3, 8'hA5, stat(~b[0], e6, 0, 0));
      e6 = ~e6;
      // R10: reset command ignored while running (R7)
      pulse_reset();
      rd("R7 reset ignored in run", 1, 8'hA5, stat(~b[0], e6, 0, 0));
      pulse_done();
      rd("R10 done returns array", 4, 8'h5A, 8'h5A);
    end

    // Sector erase sweep: R3, R4, R5, R6, R9, R10
    for (int s = 0; s < 8; s++) begin
      start(2'b01, 8'h00, s, 1'b0);
      e6 = 0; e2 = 0;
      for (int i = 0; i < 16; i++) begin
        rd("R3 R4 R5 R9 erase status", i % 8, 8'hC3, stat(0, e6, 0, e2));
        e6 = ~e6;
        if (i % 8 == s) e2 = ~e2;
      end
      suspend_i = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (i == s) begin
          rd("R3 R4 R5 suspended sector", i, 8'hC3, stat(1, e6, 0, e2));
          e2 = ~e2;
          rd("R5 suspended sector again", i, 8'hC3, stat(1, e6, 0, e2));
          e2 = ~e2;
        end else begin
          rd("R6 suspend passes other sector", i, 8'(i + 16), 8'(i + 16));
        end
      end
      pulse_done();
      rd("R10 done ignored in suspend", s, 8'hC3, stat(1, e6, 0, e2));
      e2 = ~e2;
      suspend_i = 1'b0;
      @(negedge clk);
      rd("R4 resume toggles again", (s + 1) % 8, 8'hC3, stat(0, e6, 0, e2));
      pulse_done();
      rd("R10 erase done", s, 8'h77, 8'h77);
    end

    // Chip erase: R5 flips everywhere, R6 suspend ignored
    start(2'b10, 8'h00, 0, 1'b0);
    e6 = 0; e2 = 0;
    for (int i = 0; i < 8; i++) begin
      suspend_i = (i >= 4);
      rd("R5 R6 chip erase", i, 8'h11, stat(0, e6, 0, e2));
      e6 = ~e6; e2 = ~e2;
    end
    suspend_i = 0;
    pulse_done();
    rd("R10 chip done", 0, 8'h11, 8'h11);

    // Error path R7 and toggle clear R9
    start(2'b00, 8'h00, 0, 1'b0);
    rd("R9 cleared at start", 0, 8'hEE, stat(1, 0, 0, 0));
    pulse_limit();
    e6 = 1;
    for (int i = 0; i < 4; i++) begin
      rd("R7 error set toggles live", i, 8'hEE, stat(1, e6, 1, 0));
      e6 = ~e6;
    end
    pulse_done();
    rd("R7 done ignored in error", 2, 8'hEE, stat(1, e6, 1, 0));
    e6 = ~e6;
    start(2'b10, 8'h00, 0, 1'b0);
    e6 = 0; e2 = 0;
    start(2'b01, 8'h00, 2, 1'b0);
    pulse_reset();
    rd("R7 reset clears", 2, 8'hEE, 8'hEE);
    start(2'b01, 8'h00, 2, 1'b0);
    rd("R9 clear after error", 2, 8'hEE, stat(0, 0, 0, 0));
    pulse_done();

    // Protected windows R8
    for (int k = 0; k < 2; k++) begin
      int cnt;
      int win;
      win = (k == 0) ? PW : EW;
      rd_sector_i = 0; array_data_i = 8'hFF;
      start((k == 0) ? 2'b00 : 2'b01, 8'h80, 0, 1'b1);
      cnt = 0;
      for (int i = 0; i < win + 4; i++) begin
        #2;
        if (rd_data_o !== 8'hFF) cnt++;
        @(negedge clk);
      end
      check("R8 protect window length", 8'(cnt), 8'(win));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule